// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Formatter

This unit sits between the register read stage and the data memory port of a 32-register, 32-bit load-store processor. For each accepted request it forms the effective address from a base register value plus a sign-extended 16-bit displacement. On loads it picks the addressed byte or halfword out of the 32-bit word returned by memory and widens it with sign or zero fill. On stores it copies the low byte or halfword of the source register into every lane it could occupy and raises only the byte strobes of the addressed lanes.

Lanes follow big-endian numbering. The byte at address offset 0 travels on data bits 31..24, and the byte at offset 3 travels on bits 7..0. A halfword or word access that is not naturally aligned is flagged and blocks both the write and the load result. All outputs are registered and appear one clock after the request is sampled.

Top module: `be_lsu_format`

## Requirements
- R1: With `req_valid` high at a rising edge, `eff_addr` after that edge equals `base` + `disp` modulo 2^32. Here `base` is the base register value and `disp` is the 16-bit displacement sign-extended to 32 bits. `eff_addr` holds its value while `req_valid` is low.
- R2: Register index 0 reads as zero. When `base_idx` is 0, the base is 0 whatever `base_val` holds. When `src_idx` is 0, a store writes 0 whatever `src_val` holds.
- R3: Lanes are big-endian. Byte offset `eff_addr[1:0]` = k selects data bits 31-8k down to 24-8k. A halfword at offset 0 uses bits 31..16, and a halfword at offset 2 uses bits 15..0.
- R4: A signed byte load (`req_size` = 2'b00, `req_signed` = 1) fills `ld_result[31:8]` with copies of bit 7 of the selected byte.
- R5: An unsigned load of a byte or halfword (`req_signed` = 0) fills every bit above the loaded data with zero.
- R6: A signed halfword load (`req_size` = 2'b01) returns the two selected bytes, with the lower-address byte as the more significant one, and fills `ld_result[31:16]` with copies of its bit 15.
- R7: A word load (`req_size` = 2'b10 or 2'b11) at an aligned address returns `rd_word` unchanged.
- R8: A byte store drives `wr_word` = the low source byte repeated in all four lanes. `wr_strb` is one-hot, with `wr_strb[3-k]` set for offset k, so `wr_strb[3]` is the lane of bits 31..24.
- R9: A halfword store drives `wr_word` = the low source halfword in both halves. `wr_strb` is 4'b1100 at offset 0 and 4'b0011 at offset 2.
- R10: A word store drives `wr_word` = source and `wr_strb` = 4'b1111.
- R11: A halfword at an odd address, or a word whose address is not a multiple of 4, sets `misalign`. It forces `wr_en` = 0, `wr_strb` = 0, `ld_valid` = 0, `wr_word` = 0 and `ld_result` = 0. A byte access is never misaligned.
- R12: A synchronous active-low reset clears every output to 0. A cycle with `req_valid` low yields `wr_en`, `ld_valid` and `misalign` low and `wr_strb` zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_signed | input | 1 | Sign-extend a load result |
| base_idx | input | 5 | Base register index (0 reads as zero) |
| base_val | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| src_idx | input | 5 | Store source register index (0 reads as zero) |
| src_val | input | 32 | Store source register value |
| rd_word | input | 32 | Word returned by memory for the load |
| eff_addr | output | 32 | Registered effective address |
| wr_en | output | 1 | Store accepted |
| wr_strb | output | 4 | Byte strobes, bit 3 = bits 31..24 |
| wr_word | output | 32 | Lane-replicated store data |
| ld_valid | output | 1 | Load result valid |
| ld_result | output | 32 | Extended load result |
| misalign | output | 1 | Misaligned access flagged |

## Verification
The bench walks every byte offset and both halfword offsets on loads and stores. A little-endian lane map would show up as the wrong byte and a mirrored strobe pattern. It loads bytes and halfwords whose top bit is set and whose top bit is clear, with and without sign fill, so extension from the wrong bit or zero fill on a signed load shows up as a wrong upper field. It uses negative displacements and a displacement that wraps the address, so a zero-extended displacement would give an address off by 64 KiB. It applies index 0 with a non-zero register value, which a design that ignores the zero register would pass through. It also issues every misaligned halfword and word offset, which a design with a loose alignment test would turn into a write.

// File: rtl/be_lsu_pkg.sv
// Package: shared access-size encoding for the load/store lane formatter.
// Assumes the request size is carried as a two-bit code; code 3 behaves as word.
package be_lsu_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01,
        ACC_WORD = 2'b10,
        ACC_WIDE = 2'b11
    } acc_size_e;

    // True when the code denotes a full-width access.
    function automatic logic is_full(input logic [1:0] sz);
        return sz[1];
    endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
// Module: effective-address adder.
// Adds a sign-extended displacement to the base register value. Register
// index zero is forced to read as zero. Purely combinational.
module lsu_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int IDX_W  = 5
) (
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] ea
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] base_eff;
    logic [ADDR_W-1:0] disp_ext;

    // Zero register: index 0 never exposes the stored value.
    always_comb base_eff = (base_idx == '0) ? '0 : base_val;

    // Sign-extend the displacement and add modulo 2^ADDR_W.
    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        ea       = base_eff + disp_ext;
    end
endmodule

// File: rtl/lsu_load_fmt.sv
// Module: load lane selector and extender.
// Picks a byte or halfword out of the returned word using big-endian lane
// numbering (offset 0 = most significant lane) and sign- or zero-extends it.
// Assumes the caller has already screened out misaligned requests.
module lsu_load_fmt
    import be_lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]                 rd_word,
    input  logic [$clog2(DATA_W/8)-1:0]       ofs,
    input  logic [1:0]                        size,
    input  logic                              sgn,
    output logic [DATA_W-1:0]                 result
);
    localparam int LANES  = DATA_W / 8;
    localparam int HLANES = LANES / 2;
    localparam int OFS_W  = $clog2(LANES);

    logic [7:0]  byte_lane [LANES];
    logic [15:0] half_lane [HLANES];

    // Byte lanes, lane g taken from the top end downward.
    for (genvar g = 0; g < LANES; g++) begin : g_byte
        assign byte_lane[g] = rd_word[DATA_W-1-8*g -: 8];
    end

    // Halfword lanes, lane h taken from the top end downward.
    for (genvar h = 0; h < HLANES; h++) begin : g_half
        assign half_lane[h] = rd_word[DATA_W-1-16*h -: 16];
    end

    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    // Lane pick for the current offset.
    always_comb begin
        sel_b = byte_lane[ofs];
        sel_h = half_lane[ofs[OFS_W-1:1]];
    end

    // Width-dependent extension of the selected lane.
    always_comb begin
        unique case (size)
            ACC_BYTE: result = {{(DATA_W-8){sgn & sel_b[7]}}, sel_b};
            ACC_HALF: result = {{(DATA_W-16){sgn & sel_h[15]}}, sel_h};
            default:  result = rd_word;
        endcase
    end
endmodule

// File: rtl/lsu_store_fmt.sv
// Module: store lane replicator and strobe generator.
// Copies the low byte or halfword of the source into every lane and forms
// big-endian byte strobes (strobe bit LANES-1 = offset 0). Strobes here are
// unqualified; the top gates them with validity and alignment.
module lsu_store_fmt
    import be_lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]           src,
    input  logic [$clog2(DATA_W/8)-1:0] ofs,
    input  logic [1:0]                  size,
    output logic [DATA_W-1:0]           wdata,
    output logic [DATA_W/8-1:0]         strb
);
    localparam int LANES  = DATA_W / 8;
    localparam int HLANES = LANES / 2;
    localparam int OFS_W  = $clog2(LANES);

    logic [LANES-1:0] one_lane;
    logic [LANES-1:0] two_lane;

    // Strobe patterns for a single byte and for a halfword pair.
    always_comb begin
        one_lane = LANES'(1) << (LANES - 1 - int'(ofs));
        two_lane = LANES'(3) << (LANES - 2 - 2 * int'(ofs[OFS_W-1:1]));
    end

    // Data replication and strobe choice by access width.
    always_comb begin
        unique case (size)
            ACC_BYTE: begin
                wdata = {LANES{src[7:0]}};
                strb  = one_lane;
            end
            ACC_HALF: begin
                wdata = {HLANES{src[15:0]}};
                strb  = two_lane;
            end
            default: begin
                wdata = src;
                strb  = '1;
            end
        endcase
    end
endmodule

// File: rtl/lsu_align_chk.sv
// Module: natural-alignment test.
// Flags a halfword at an odd offset or a full word at any non-zero offset.
// Byte accesses always pass.
module lsu_align_chk
    import be_lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [$clog2(DATA_W/8)-1:0] ofs,
    input  logic [1:0]                  size,
    output logic                        bad
);
    // Alignment rule per width.
    always_comb begin
        unique case (size)
            ACC_BYTE: bad = 1'b0;
            ACC_HALF: bad = ofs[0];
            default:  bad = (ofs != '0);
        endcase
    end
endmodule

// File: rtl/be_lsu_format.sv
// Module: top of the big-endian load/store lane formatter.
// Forms the effective address, formats load data and store lanes, screens
// alignment, and registers all results one cycle after the request.
// Assumes rd_word is the aligned memory word for this request's address,
// presented in the same cycle as the request. Synchronous active-low reset.
module be_lsu_format
    import be_lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DISP_W = 16,
    parameter int IDX_W  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_store,
    input  logic [1:0]          req_size,
    input  logic                req_signed,
    input  logic [IDX_W-1:0]    base_idx,
    input  logic [DATA_W-1:0]   base_val,
    input  logic [DISP_W-1:0]   disp,
    input  logic [IDX_W-1:0]    src_idx,
    input  logic [DATA_W-1:0]   src_val,
    input  logic [DATA_W-1:0]   rd_word,
    output logic [DATA_W-1:0]   eff_addr,
    output logic                wr_en,
    output logic [DATA_W/8-1:0] wr_strb,
    output logic [DATA_W-1:0]   wr_word,
    output logic                ld_valid,
    output logic [DATA_W-1:0]   ld_result,
    output logic                misalign
);
    localparam int LANES = DATA_W / 8;
    localparam int OFS_W = $clog2(LANES);

    logic [DATA_W-1:0] ea;
    logic [OFS_W-1:0]  ofs;
    logic [DATA_W-1:0] src_eff;
    logic [DATA_W-1:0] ld_fmt;
    logic [DATA_W-1:0] st_word;
    logic [LANES-1:0]  st_strb;
    logic              bad_align;
    logic              do_store;
    logic              do_load;

    lsu_addr_gen #(.ADDR_W(DATA_W), .DISP_W(DISP_W), .IDX_W(IDX_W)) u_addr (
        .base_idx (base_idx),
        .base_val (base_val),
        .disp     (disp),
        .ea       (ea)
    );

    // Byte offset within the word and zero-register handling for the source.
    always_comb begin
        ofs     = ea[OFS_W-1:0];
        src_eff = (src_idx == '0) ? '0 : src_val;
    end

    lsu_align_chk #(.DATA_W(DATA_W)) u_align (
        .ofs  (ofs),
        .size (req_size),
        .bad  (bad_align)
    );

    lsu_load_fmt #(.DATA_W(DATA_W)) u_load (
        .rd_word (rd_word),
        .ofs     (ofs),
        .size    (req_size),
        .sgn     (req_signed),
        .result  (ld_fmt)
    );

    lsu_store_fmt #(.DATA_W(DATA_W)) u_store (
        .src   (src_eff),
        .ofs   (ofs),
        .size  (req_size),
        .wdata (st_word),
        .strb  (st_strb)
    );

    // Qualify the request: accepted only when valid and aligned.
    always_comb begin
        do_store = req_valid &  req_store & ~bad_align;
        do_load  = req_valid & ~req_store & ~bad_align;
    end

    // Output registers, cleared by reset, gated by acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_addr  <= '0;
            wr_en     <= 1'b0;
            wr_strb   <= '0;
            wr_word   <= '0;
            ld_valid  <= 1'b0;
            ld_result <= '0;
            misalign  <= 1'b0;
        end else begin
            if (req_valid) eff_addr <= ea;
            wr_en     <= do_store;
            wr_strb   <= do_store ? st_strb : '0;
            wr_word   <= do_store ? st_word : '0;
            ld_valid  <= do_load;
            ld_result <= do_load ? ld_fmt : '0;
            misalign  <= req_valid & bad_align;
        end
    end
endmodule

// File: rtl/be_lsu_checker.sv
// Module: property checker for be_lsu_format, attached by bind below.
// Relates registered outputs to the request sampled one cycle earlier.
module be_lsu_checker #(
    parameter int DATA_W = 32,
    parameter int DISP_W = 16,
    parameter int IDX_W  = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_store,
    input logic [1:0]          req_size,
    input logic                req_signed,
    input logic [IDX_W-1:0]    base_idx,
    input logic [DATA_W-1:0]   base_val,
    input logic [DISP_W-1:0]   disp,
    input logic [IDX_W-1:0]    src_idx,
    input logic [DATA_W-1:0]   eff_addr,
    input logic                wr_en,
    input logic [DATA_W/8-1:0] wr_strb,
    input logic [DATA_W-1:0]   wr_word,
    input logic                ld_valid,
    input logic [DATA_W-1:0]   ld_result,
    input logic                misalign
);
    logic [DATA_W-1:0] exp_base;
    logic [DATA_W-1:0] exp_disp;

    // Reference base and displacement for the address property.
    always_comb begin
        exp_base = (base_idx == '0) ? '0 : base_val;
        exp_disp = DATA_W'($signed(disp));
    end

    // R1: registered address is base plus signed displacement.
    a_r1_ea_sum: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (eff_addr == $past(exp_base) + $past(exp_disp)));

    // R2: index-0 source produces all-zero store data.
    a_r2_zero_source: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && src_idx == '0) |=> (wr_word == '0));

    // R5: unsigned byte load leaves the upper field clear.
    a_r5_unsigned_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && req_size == 2'b00 && !req_signed)
        |=> (ld_result[DATA_W-1:8] == '0));

    // R8, R9, R10: an accepted store raises one, two or four strobes.
    a_r10_strobe_count: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(wr_strb) == 1 || $countones(wr_strb) == 2 ||
                   $countones(wr_strb) == DATA_W/8));

    // R11: a flagged access neither writes nor returns data.
    a_r11_misalign_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!wr_en && wr_strb == '0 && !ld_valid));

    // R12: an idle cycle is followed by quiet outputs.
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!wr_en && !ld_valid && !misalign && wr_strb == '0));

    // R11: load and store results never coexist.
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && ld_valid));
endmodule

bind be_lsu_format be_lsu_checker #(
    .DATA_W(DATA_W), .DISP_W(DISP_W), .IDX_W(IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_store  (req_store),
    .req_size   (req_size),
    .req_signed (req_signed),
    .base_idx   (base_idx),
    .base_val   (base_val),
    .disp       (disp),
    .src_idx    (src_idx),
    .eff_addr   (eff_addr),
    .wr_en      (wr_en),
    .wr_strb    (wr_strb),
    .wr_word    (wr_word),
    .ld_valid   (ld_valid),
    .ld_result  (ld_result),
    .misalign   (misalign)
);

// File: tb/sim_be_lsu_format.sv
// Directed bench for be_lsu_format: one task per scenario, each self-checking.
module sim_be_lsu_format;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_signed = 1'b0;
    logic [4:0]  base_idx = 5'd0;
    logic [31:0] base_val = 32'd0;
    logic [15:0] disp = 16'd0;
    logic [4:0]  src_idx = 5'd0;
    logic [31:0] src_val = 32'd0;
    logic [31:0] rd_word = 32'd0;
    logic [31:0] eff_addr;
    logic        wr_en;
    logic [3:0]  wr_strb;
    logic [31:0] wr_word;
    logic        ld_valid;
    logic [31:0] ld_result;
    logic        misalign;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    be_lsu_format u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_signed(req_signed), .base_idx(base_idx),
        .base_val(base_val), .disp(disp), .src_idx(src_idx), .src_val(src_val),
        .rd_word(rd_word), .eff_addr(eff_addr), .wr_en(wr_en), .wr_strb(wr_strb),
        .wr_word(wr_word), .ld_valid(ld_valid), .ld_result(ld_result),
        .misalign(misalign)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one request at the falling edge; sample one edge later.
    task automatic issue(input logic st, input logic [1:0] sz, input logic sg,
                         input logic [4:0] bi, input logic [31:0] bv,
                         input logic [15:0] dp, input logic [4:0] si,
                         input logic [31:0] sv, input logic [31:0] rw);
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_size = sz; req_signed = sg;
        base_idx = bi; base_val = bv; disp = dp; src_idx = si; src_val = sv;
        rd_word = rw;
        @(posedge clk);
        #1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 reset eff_addr", eff_addr, 32'd0);
        chk("R12 reset wr_en", {31'd0, wr_en}, 32'd0);
        chk("R12 reset wr_strb", {28'd0, wr_strb}, 32'd0);
        chk("R12 reset ld_valid", {31'd0, ld_valid}, 32'd0);
        chk("R12 reset misalign", {31'd0, misalign}, 32'd0);
    endtask

    task automatic t_address();
        issue(1'b0, 2'b10, 1'b0, 5'd4, 32'h0000_1000, 16'h0010, 5'd0, 0, 0);
        chk("R1 positive disp", eff_addr, 32'h0000_1010);
        issue(1'b0, 2'b10, 1'b0, 5'd4, 32'h0000_1000, 16'hFFF0, 5'd0, 0, 0);
        chk("R1 negative disp", eff_addr, 32'h0000_0FF0);
        issue(1'b0, 2'b00, 1'b0, 5'd7, 32'h0000_0004, 16'h8000, 5'd0, 0, 0);
        chk("R1 wrap below zero", eff_addr, 32'hFFFF_8004);
        issue(1'b0, 2'b10, 1'b0, 5'd0, 32'hABCD_0000, 16'h0100, 5'd0, 0, 0);
        chk("R2 base index zero", eff_addr, 32'h0000_0100);
        // Idle cycle: address holds.
        @(posedge clk); #1;
        chk("R1 hold when idle", eff_addr, 32'h0000_0100);
    endtask

    task automatic t_load_bytes();
        logic [31:0] w;
        w = 32'h807F_C301;
        for (int o = 0; o < 4; o++) begin
            for (int s = 0; s < 2; s++) begin
                logic [7:0] b;
                logic [31:0] e;
                b = 8'(w >> (8 * (3 - o)));
                e = (s == 1) ? {{24{b[7]}}, b} : {24'd0, b};
                issue(1'b0, 2'b00, s[0], 5'd3, 32'h0000_2000, 16'(o), 5'd0, 0, w);
                chk((s == 1) ? "R4 R3 signed byte" : "R5 R3 unsigned byte", ld_result, e);
                chk("R3 byte ld_valid", {31'd0, ld_valid}, 32'd1);
            end
        end
    endtask

    task automatic t_load_halves();
        logic [31:0] w;
        w = 32'h8001_7FFE;
        chk_half(w, 0, 1'b1, 32'hFFFF_8001, "R6 R3 signed half off0");
        chk_half(w, 0, 1'b0, 32'h0000_8001, "R5 unsigned half off0");
        chk_half(w, 2, 1'b1, 32'h0000_7FFE, "R6 R3 signed half off2");
        chk_half(w, 2, 1'b0, 32'h0000_7FFE, "R5 unsigned half off2");
    endtask

    task automatic chk_half(input logic [31:0] w, input int o, input logic sg,
                            input logic [31:0] e, input string tag);
        issue(1'b0, 2'b01, sg, 5'd3, 32'h0000_3000, 16'(o), 5'd0, 0, w);
        chk(tag, ld_result, e);
    endtask

    task automatic t_load_word();
        issue(1'b0, 2'b10, 1'b1, 5'd3, 32'h0000_4000, 16'h0008, 5'd0, 0, 32'hF1E2_D3C4);
        chk("R7 word load", ld_result, 32'hF1E2_D3C4);
        issue(1'b0, 2'b11, 1'b0, 5'd3, 32'h0000_4000, 16'h0004, 5'd0, 0, 32'h0123_4567);
        chk("R7 word load size 3", ld_result, 32'h0123_4567);
        chk("R7 no write on load", {31'd0, wr_en}, 32'd0);
    endtask

    task automatic t_store_byte();
        for (int o = 0; o < 4; o++) begin
            issue(1'b1, 2'b00, 1'b0, 5'd2, 32'h0000_5000, 16'(o), 5'd9, 32'hDEAD_BEA5, 0);
            chk("R8 byte store data", wr_word, 32'hA5A5_A5A5);
            chk("R8 R3 byte strobe", {28'd0, wr_strb}, 32'(4'b1000 >> o));
            chk("R8 byte wr_en", {31'd0, wr_en}, 32'd1);
        end
    endtask

    task automatic t_store_half();
        issue(1'b1, 2'b01, 1'b0, 5'd2, 32'h0000_6000, 16'h0000, 5'd9, 32'h1234_F00D, 0);
        chk("R9 half store data", wr_word, 32'hF00D_F00D);
        chk("R9 half strobe off0", {28'd0, wr_strb}, 32'h0000_000C);
        issue(1'b1, 2'b01, 1'b0, 5'd2, 32'h0000_6000, 16'h0002, 5'd9, 32'h1234_F00D, 0);
        chk("R9 half strobe off2", {28'd0, wr_strb}, 32'h0000_0003);
    endtask

    task automatic t_store_word();
        issue(1'b1, 2'b10, 1'b0, 5'd2, 32'h0000_7000, 16'h0004, 5'd9, 32'hCAFE_0042, 0);
        chk("R10 word store data", wr_word, 32'hCAFE_0042);
        chk("R10 word strobe", {28'd0, wr_strb}, 32'h0000_000F);
        issue(1'b1, 2'b10, 1'b0, 5'd2, 32'h0000_7000, 16'h0004, 5'd0, 32'hCAFE_0042, 0);
        chk("R2 source index zero", wr_word, 32'd0);
        chk("R2 source zero still writes", {31'd0, wr_en}, 32'd1);
    endtask

    task automatic t_misalign();
        for (int o = 1; o < 4; o += 2) begin
            issue(1'b1, 2'b01, 1'b0, 5'd2, 32'h0000_8000, 16'(o), 5'd9, 32'hFFFF_FFFF, 0);
            chk("R11 odd half flag", {31'd0, misalign}, 32'd1);
            chk("R11 odd half no write", {27'd0, wr_en, wr_strb}, 32'd0);
        end
        for (int o = 1; o < 4; o++) begin
            issue(1'b0, 2'b10, 1'b0, 5'd2, 32'h0000_8000, 16'(o), 5'd0, 0, 32'h1111_2222);
            chk("R11 word load flag", {31'd0, misalign}, 32'd1);
            chk("R11 word load blocked", {31'd0, ld_valid}, 32'd0);
            chk("R11 word load result zero", ld_result, 32'd0);
            issue(1'b1, 2'b10, 1'b0, 5'd2, 32'h0000_8000, 16'(o), 5'd9, 32'h5555_5555, 0);
            chk("R11 word store blocked", {27'd0, wr_en, wr_strb}, 32'd0);
        end
        issue(1'b1, 2'b00, 1'b0, 5'd2, 32'h0000_8000, 16'h0003, 5'd9, 32'h0000_0077, 0);
        chk("R11 byte never misaligned", {31'd0, misalign}, 32'd0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        req_valid = 1'b0; req_store = 1'b1; req_size = 2'b01; disp = 16'h0001;
        @(posedge clk); #1;
        chk("R12 idle no write", {31'd0, wr_en}, 32'd0);
        chk("R12 idle no misalign", {31'd0, misalign}, 32'd0);
        chk("R12 idle no load", {31'd0, ld_valid}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_address();
        t_load_bytes();
        t_load_halves();
        t_load_word();
        t_store_byte();
        t_store_half();
        t_store_word();
        t_misalign();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule